// File: doc/BRIEF.md
# Triggered Single-Clock Strobe Timer

A timer channel that waits a programmed number of clocks and then drops its output low for exactly one clock. It has two ways to start. In software-start mode, completing the count write starts the sequence, and the gate level can hold the countdown. In hardware-start mode, a rising edge on the gate starts the sequence. A later edge restarts it from the stored count, and the gate level does not affect counting.

The count is 16 bits wide and is written one byte at a time, low byte first. A control write picks the start mode, clears all sequencing state and forces the output high in the same cycle. The clock that loads the count does not decrement it, so a count N gives a strobe N+1 clocks after the start. Once the count expires, the counter keeps running and wraps without strobing again. Everything is synchronous to the rising edge of `clk_i`.

Top module: `tmr_strobe`

## Requirements
- R1: While reset is asserted, and after reset until a count has been programmed and started, `out_o` is high.
- R2: In software-start mode with `gate_i` high, a count N (1 to 65535) gives `out_o` low for exactly one clock. The low cycle follows the (N+1)th rising edge counted from the edge that accepts the second count byte, with that edge as edge 0.
- R3: In software-start mode, each edge after the load edge at which `gate_i` is low leaves the count unchanged, so the strobe is delayed by one clock per such edge. A low gate never drives `out_o` low.
- R4: Count bytes go low byte first, then high byte. In software-start mode, a complete new count written during a sequence is loaded on the next edge, and the strobe comes N+1 edges after the new count's second byte. A first byte written alone does not change the running sequence.
- R5: In hardware-start mode, writing a count starts nothing. A rising edge of `gate_i` (low at one edge, high at the next, which is edge 0) produces the strobe N+1 edges later, whatever `gate_i` does after that edge.
- R6: In hardware-start mode, a count written during a sequence does not change that sequence. A new rising edge before expiry restarts the sequence with the latest complete count, and the strobe comes N+1 edges after that edge.
- R7: In hardware-start mode, a gate rising edge seen after a control write but before a complete count has been written is ignored.
- R8: After the strobe, the counter wraps through 0xFFFF and keeps counting without another strobe.
- R9: A count of 0 stands for 65536 and gives the strobe 65537 edges after the start.
- R10: While `ctrl_wr_i` is high, `out_o` is high in that same cycle. The control write cancels any sequence in progress.
- R11: `mode_i` is sampled only when `ctrl_wr_i` is high (0 = software start, 1 = hardware start). Changing it at any other time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_wr_i | input | 1 | Control write: latches the start mode and clears the channel |
| mode_i | input | 1 | Start mode for the control write: 0 software, 1 hardware |
| cnt_wr_i | input | 1 | Count byte write strobe |
| cnt_byte_i | input | 8 | Count byte, low byte first |
| gate_i | input | 1 | Gate: holds the countdown (software mode) or starts it on a rising edge (hardware mode) |
| out_o | output | 1 | Strobe output, high at rest, low for one clock at expiry |

## Verification
The hardest case to reach is a hardware restart at the boundary: a gate edge that lands on the last clock before the old count would expire, so that the reload and the expiry compete at the same edge. The stimulus sweeps the restart edge across every position from the first decrement up to that last clock, and counts how many low cycles appear. Two full wraps of the 16-bit counter are run as well, one after a short count and one with count 0, so that both the silent wrap and the 65536 count are observed at the output.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic {
    TRG_SW = 1'b0,
    TRG_HW = 1'b1
  } trg_mode_e;
endpackage

// File: rtl/tmr_wr_asm.sv
module tmr_wr_asm #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [CNT_W-1:0]  init_o,
  output logic              done_o,
  output logic              vld_o
);
  localparam int unsigned NB = CNT_W / BYTE_W;
  localparam int unsigned PW = (NB > 1) ? $clog2(NB) : 1;
  localparam int unsigned NS = (NB > 1) ? NB - 1 : 1;

  logic [PW-1:0]     ptr_q;
  logic [BYTE_W-1:0] stage_q [NS];
  logic [CNT_W-1:0]  init_q, init_nxt;
  logic              vld_q;

  assign done_o = wr_i && !clr_i && (ptr_q == PW'(NB - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (clr_i) ptr_q <= '0;
    else if (wr_i)  ptr_q <= (ptr_q == PW'(NB - 1)) ? '0 : ptr_q + 1'b1;
  end

  // staging for all bytes but the last
  for (genvar b = 0; b < NB - 1; b++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 stage_q[b] <= '0;
      else if (wr_i && !clr_i && ptr_q == PW'(b))  stage_q[b] <= byte_i;
    end
  end

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      if (b == NB - 1) init_nxt[b*BYTE_W +: BYTE_W] = byte_i;
      else             init_nxt[b*BYTE_W +: BYTE_W] = stage_q[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= '0;
      vld_q  <= 1'b0;
    end else if (clr_i) begin
      vld_q  <= 1'b0;
    end else if (done_o) begin
      init_q <= init_nxt;
      vld_q  <= 1'b1;
    end
  end

  assign init_o = init_q;
  assign vld_o  = vld_q;
endmodule

// File: rtl/tmr_trig.sv
module tmr_trig
  import tmr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clr_i,
  input  trg_mode_e mode_i,
  input  logic      gate_i,
  input  logic      done_i,
  input  logic      vld_i,
  output logic      ld_o
);
  logic gate_q, pend_q, rise;

  assign rise = gate_i && !gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= gate_i;
  end

  // load request lands one edge after the start event
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pend_q <= 1'b0;
    else if (clr_i)            pend_q <= 1'b0;
    else if (mode_i == TRG_HW) pend_q <= rise && (vld_i || done_i);
    else                       pend_q <= done_i;
  end

  assign ld_o = pend_q;
endmodule

// File: rtl/tmr_cnt.sv
module tmr_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] init_i,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             strb_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, armed_q, strb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      armed_q <= 1'b0;
      strb_q  <= 1'b0;
    end else if (clr_i) begin
      run_q   <= 1'b0;
      armed_q <= 1'b0;
      strb_q  <= 1'b0;
    end else begin
      strb_q <= 1'b0;
      if (ld_i) begin
        cnt_q   <= init_i;
        run_q   <= 1'b1;
        armed_q <= 1'b1;
      end else if (run_q && en_i) begin
        cnt_q <= cnt_q - 1'b1;
        if (armed_q && cnt_q == CNT_W'(1)) begin
          strb_q  <= 1'b1;
          armed_q <= 1'b0;
        end
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign run_o  = run_q;
  assign strb_o = strb_q;
endmodule

// File: rtl/tmr_strobe.sv
module tmr_strobe
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic              mode_i,
  input  logic              cnt_wr_i,
  input  logic [BYTE_W-1:0] cnt_byte_i,
  input  logic              gate_i,
  output logic              out_o
);
  trg_mode_e        mode_q;
  logic             mode_hw, wr_done, cnt_vld, ld, run, strb;
  logic [CNT_W-1:0] init_cnt, cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= TRG_SW;
    else if (ctrl_wr_i) mode_q <= trg_mode_e'(mode_i);
  end

  assign mode_hw = (mode_q == TRG_HW);

  tmr_wr_asm #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_wr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ctrl_wr_i),
    .wr_i   (cnt_wr_i),
    .byte_i (cnt_byte_i),
    .init_o (init_cnt),
    .done_o (wr_done),
    .vld_o  (cnt_vld)
  );

  tmr_trig u_trig (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ctrl_wr_i),
    .mode_i (mode_q),
    .gate_i (gate_i),
    .done_i (wr_done),
    .vld_i  (cnt_vld),
    .ld_o   (ld)
  );

  tmr_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ctrl_wr_i),
    .ld_i   (ld),
    .init_i (init_cnt),
    .en_i   (mode_hw || gate_i),
    .cnt_o  (cnt),
    .run_o  (run),
    .strb_o (strb)
  );

  // control write forces the idle level without waiting for a clock
  assign out_o = !(strb && !ctrl_wr_i);
endmodule

// File: rtl/tmr_strobe_chk.sv
module tmr_strobe_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctrl_wr_i,
  input logic             gate_i,
  input logic             out_o,
  input logic             hw,
  input logic             ld,
  input logic             done,
  input logic             run,
  input logic [CNT_W-1:0] init,
  input logic [CNT_W-1:0] cnt
);
  AST_STROBE_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_o |=> out_o); // R2

  AST_LOAD_NO_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld && !ctrl_wr_i) |=> (run && cnt == $past(init))); // R2

  AST_SW_PAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hw && !gate_i && !ld && !ctrl_wr_i) |=> $stable(cnt)); // R3

  AST_SW_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hw && done && !ctrl_wr_i) |=> ld); // R4

  AST_HW_NEEDS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw && !$past(gate_i)) |-> !ld); // R5

  AST_WRAP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && cnt == '0 && (hw || gate_i) && !ld && !ctrl_wr_i) |=> (cnt == '1 && out_o)); // R8

  AST_CTRL_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i |=> (out_o && !ld)); // R10
endmodule

bind tmr_strobe tmr_strobe_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ctrl_wr_i (ctrl_wr_i),
  .gate_i    (gate_i),
  .out_o     (out_o),
  .hw        (mode_hw),
  .ld        (ld),
  .done      (wr_done),
  .run       (run),
  .init      (init_cnt),
  .cnt       (cnt)
);

// File: tb/tmr_strobe_tb.sv
module tmr_strobe_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_wr = 1'b0, mode = 1'b0, cnt_wr = 1'b0, gate = 1'b0;
  logic [7:0] cnt_byte = '0;
  logic       out;

  int n_chk = 0, n_fail = 0, cyc = 0, lows = 0, low_at = -1, t0 = 0;

  always #2 clk = ~clk;

  tmr_strobe u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_wr_i(ctrl_wr), .mode_i(mode),
    .cnt_wr_i(cnt_wr), .cnt_byte_i(cnt_byte), .gate_i(gate), .out_o(out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    if (!out) begin
      lows++;
      if (low_at < 0) low_at = cyc;
    end
  endtask

  task automatic ticks(input int k);
    repeat (k) tick();
  endtask

  task automatic mon_clr();
    lows = 0;
    low_at = -1;
  endtask

  task automatic ctrl(input bit hw);
    ctrl_wr = 1'b1;
    mode = hw;
    #1;
    chk(out == 1'b1, "R10", out, 1);
    tick();
    ctrl_wr = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] b);
    cnt_wr = 1'b1;
    cnt_byte = b;
    tick();
    cnt_wr = 1'b0;
  endtask

  task automatic wr_cnt(input int n);
    wr_byte(n[7:0]);
    wr_byte(n[15:8]);
  endtask

  task automatic hw_trig();
    gate = 1'b0;
    tick();
    gate = 1'b1;
    tick();
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    ticks(3);
    chk(out == 1'b1, "R1", out, 1);
    rst_n = 1'b1;
    mon_clr();
    ticks(10);
    chk(lows == 0, "R1", lows, 0);

    // R2 software start sweep
    for (int n = 1; n <= 20; n++) begin
      ctrl(1'b0);
      gate = 1'b1;
      wr_cnt(n);
      t0 = cyc;
      mon_clr();
      ticks(n + 4);
      chk(low_at - t0 == n + 1, "R2", low_at - t0, n + 1);
      chk(lows == 1, "R2", lows, 1);
    end

    // R3 gate pause
    for (int l = 0; l <= 6; l++) begin
      int n = (l == 6) ? 3 : 10;
      int lp = (l == 6) ? 8 : l;
      ctrl(1'b0);
      gate = 1'b1;
      wr_cnt(n);
      t0 = cyc;
      mon_clr();
      ticks(3 - ((l == 6) ? 0 : 0));
      gate = 1'b0;
      ticks(lp);
      chk(lows == 0, "R3", lows, 0);
      gate = 1'b1;
      ticks(n + 4);
      chk(low_at - t0 == n + 1 + lp, "R3", low_at - t0, n + 1 + lp);
      chk(lows == 1, "R3", lows, 1);
    end

    // R4 reload mid sequence, byte order
    ctrl(1'b0);
    gate = 1'b1;
    wr_cnt(20);
    t0 = cyc;
    mon_clr();
    ticks(5);
    wr_byte(8'd3);
    ticks(3);
    wr_byte(8'd0);
    ticks(14);
    chk(low_at - t0 == 14, "R4", low_at - t0, 14);
    chk(lows == 1, "R4", lows, 1);

    ctrl(1'b0);
    wr_cnt(20);
    t0 = cyc;
    mon_clr();
    ticks(5);
    wr_byte(8'd3);
    ticks(20);
    chk(low_at - t0 == 21, "R4", low_at - t0, 21);
    chk(lows == 1, "R4", lows, 1);

    ctrl(1'b0);
    wr_cnt(300);
    t0 = cyc;
    mon_clr();
    ticks(305);
    chk(low_at - t0 == 301, "R4", low_at - t0, 301);

    // R11 mode ignored outside control write
    ctrl(1'b0);
    gate = 1'b1;
    wr_cnt(6);
    t0 = cyc;
    mon_clr();
    mode = 1'b1;
    ticks(2);
    gate = 1'b0;
    ticks(3);
    gate = 1'b1;
    ticks(10);
    chk(low_at - t0 == 10, "R11", low_at - t0, 10);
    mode = 1'b0;

    // R5 hardware start sweep
    for (int n = 1; n <= 12; n++) begin
      ctrl(1'b1);
      gate = 1'b0;
      wr_cnt(n);
      mon_clr();
      ticks(2 * n + 3);
      chk(lows == 0, "R5", lows, 0);
      gate = 1'b1;
      tick();
      t0 = cyc;
      mon_clr();
      if (n % 2 == 1) gate = 1'b0;
      ticks(n + 4);
      chk(low_at - t0 == n + 1, "R5", low_at - t0, n + 1);
      chk(lows == 1, "R5", lows, 1);
    end

    // R6 count written mid sequence, then used by next trigger
    ctrl(1'b1);
    wr_cnt(10);
    hw_trig();
    t0 = cyc;
    mon_clr();
    ticks(2);
    wr_cnt(4);
    ticks(10);
    chk(low_at - t0 == 11, "R6", low_at - t0, 11);
    chk(lows == 1, "R6", lows, 1);
    hw_trig();
    t0 = cyc;
    mon_clr();
    ticks(8);
    chk(low_at - t0 == 5, "R6", low_at - t0, 5);

    // R6 retrigger position sweep up to the expiry boundary
    for (int r = 2; r <= 10; r++) begin
      ctrl(1'b1);
      wr_cnt(10);
      hw_trig();
      t0 = cyc;
      mon_clr();
      ticks(r - 2);
      gate = 1'b0;
      tick();
      gate = 1'b1;
      tick();
      ticks(14);
      chk(low_at - t0 == r + 11, "R6", low_at - t0, r + 11);
      chk(lows == 1, "R6", lows, 1);
    end

    // R7 edge before count is ignored
    ctrl(1'b1);
    hw_trig();
    wr_cnt(5);
    mon_clr();
    ticks(20);
    chk(lows == 0, "R7", lows, 0);
    hw_trig();
    t0 = cyc;
    mon_clr();
    ticks(10);
    chk(low_at - t0 == 6, "R7", low_at - t0, 6);

    // R10 immediate force high, then cancel
    ctrl(1'b0);
    gate = 1'b1;
    wr_cnt(5);
    t0 = cyc;
    mon_clr();
    ticks(6);
    chk(out == 1'b0, "R2", out, 0);
    ctrl(1'b0);
    wr_cnt(10);
    ticks(4);
    ctrl(1'b0);
    mon_clr();
    ticks(20);
    chk(lows == 0, "R10", lows, 0);

    // R8 silent wrap
    ctrl(1'b0);
    gate = 1'b1;
    wr_cnt(3);
    t0 = cyc;
    mon_clr();
    ticks(65545);
    chk(low_at - t0 == 4, "R8", low_at - t0, 4);
    chk(lows == 1, "R8", lows, 1);

    // R9 zero means 65536
    ctrl(1'b0);
    wr_cnt(0);
    t0 = cyc;
    mon_clr();
    ticks(65540);
    chk(low_at - t0 == 65537, "R9", low_at - t0, 65537);
    chk(lows == 1, "R9", lows, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule